// File: doc/BRIEF.md
# Interconnect Performance Monitor

This block counts traffic events for a multi-port interconnect and exposes the counts through a small memory-mapped register port. It holds five 32-bit counters. Counter 0 counts clock cycles. Counters 1 to 4 each count one event, chosen by software from a 256-bit vector of single-cycle event pulses. That vector carries 32 event codes for each of 8 ports.

Each counter has its own 4 KB register window holding four registers: the event choice, the count, a local enable and a sticky overflow flag. A global control word in the first window gates all counting at once. Software can preload a count, so a counter can be set close to its wrap point. When a counter wraps, its overflow flag is set and that counter's own interrupt line is raised. The interrupt stays high until software clears the flag.

Reads return their data on the clock edge after the request. Unmapped addresses read as zero.

Top module: `perf_mon_top`

## Requirements
- R1: After reset all counts, event choices, local enables, overflow flags, the global enable and every interrupt line are zero.
- R2: Counter i occupies the window at address i*0x1000. Within a window, offset 0x000 holds the event choice (8 bits), 0x004 the count, 0x008 the local enable (bit 0) and 0x00C the overflow flag (bit 0). The event choice, count and local enable read back what was written.
- R3: A counter advances only in a cycle where both the global enable (bit 0 at 0x100) and its own local enable are 1. Otherwise the count holds.
- R4: Counter 0 advances by one on every cycle it is enabled. Its event choice is stored but has no effect on counting.
- R5: An event counter whose choice is value s advances by one in each enabled cycle in which event pulse bit s is high. Bits 7:5 of s give the port and bits 4:0 give the code, so s = port*32 + code. Pulses on any other bit do not move it.
- R6: Ports 0 to 4 accept codes 0x00 to 0x14 and ports 5 to 7 accept codes 0x00 to 0x11. A choice with any other code never advances the counter, even when its pulse bit is high.
- R7: When a count steps from 0xFFFFFFFF to 0, overflow bit 0 of that counter is set and its interrupt line is high while the bit is set. Writing 1 to bit 0 clears the flag. Writing 0 leaves it unchanged. If a new wrap happens in the same cycle as a clear, the flag stays set.
- R8: A count write in the same cycle as an increment wins: the count becomes the written value.
- R9: The global control word at 0x100 returns the global enable in bit 0 and the number of event counters (4) in bits 15:11. The identification word at 0xFE8 returns the revision (5) in bits 7:4. Both are decoded only in window 0.
- R10: Reads of unmapped addresses return 0. Writes to read-only bits or unmapped addresses change no readable state.
- R11: Read data appears on the edge after the read request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address; bits 15:12 select the window |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, registered |
| evt_pulse | input | 256 | Event pulses; bit port*32+code |
| ovf_irq | output | 5 | Per-counter overflow interrupt |

## Verification
The bench builds the block with its default parameters: four event counters, 32-bit counts, revision 5, last valid slave code 0x14 and last valid master code 0x11. Preloading a count of 0xFFFFFFFE brings the wrap and the overflow interrupt within three cycles. The default code limits let the bench place event choices exactly on the last valid code and one code past it, for both port types, and drive every pulse line at once. This shows that only the selected, valid bit is counted.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;
  localparam int DATA_W    = 32;
  localparam int WIN_LSB   = 12;
  localparam int OFF_W     = 12;
  localparam int PORT_W    = 3;
  localparam int CODE_W    = 5;
  localparam int SEL_W     = PORT_W + CODE_W;
  localparam int NUM_PORTS = 1 << PORT_W;
  localparam int NUM_CODES = 1 << CODE_W;
  localparam int EVT_W     = NUM_PORTS * NUM_CODES;
  localparam int NCNT_LSB  = 11;
  localparam int NCNT_W    = 5;
  localparam int REV_LSB   = 4;

  localparam logic [OFF_W-1:0] OFF_SEL  = 12'h000;
  localparam logic [OFF_W-1:0] OFF_CNT  = 12'h004;
  localparam logic [OFF_W-1:0] OFF_CTL  = 12'h008;
  localparam logic [OFF_W-1:0] OFF_OVF  = 12'h00C;
  localparam logic [OFF_W-1:0] OFF_GCTL = 12'h100;
  localparam logic [OFF_W-1:0] OFF_ID   = 12'hFE8;
endpackage

// File: rtl/pm_event_filter.sv
module pm_event_filter import perfmon_pkg::*; #(
  parameter int SLV_MAX_CODE   = 20,
  parameter int MST_MAX_CODE   = 17,
  parameter int FIRST_MST_PORT = 5
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [EVT_W-1:0] evt,
  output logic             code_ok,
  output logic             hit
);
  logic [PORT_W-1:0] port;
  logic [CODE_W-1:0] code;
  logic              is_master;

  always_comb begin
    port      = sel[SEL_W-1:CODE_W];
    code      = sel[CODE_W-1:0];
    is_master = (port >= PORT_W'(FIRST_MST_PORT));
    code_ok   = is_master ? (code <= CODE_W'(MST_MAX_CODE))
                          : (code <= CODE_W'(SLV_MAX_CODE));
    hit       = code_ok & evt[sel];
  end
endmodule

// File: rtl/pm_counter_slot.sv
module pm_counter_slot import perfmon_pkg::*; #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             g_en,
  input  logic             evt_hit,
  input  logic             code_ok,
  input  logic             wr_sel,
  input  logic             wr_cnt,
  input  logic             wr_ctl,
  input  logic             wr_ovf,
  input  logic [CNT_W-1:0] wdata,
  output logic [SEL_W-1:0] sel_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             en_q,
  output logic             ovf_q
);
  logic [SEL_W-1:0] sel_d;
  logic [CNT_W-1:0] cnt_d;
  logic             en_d, ovf_d, inc, wrap;

  always_comb begin
    inc   = g_en & en_q & evt_hit;
    wrap  = inc & ~wr_cnt & (&cnt_q);
    sel_d = wr_sel ? wdata[SEL_W-1:0] : sel_q;
    en_d  = wr_ctl ? wdata[0] : en_q;
    cnt_d = cnt_q;
    if (wr_cnt)   cnt_d = wdata;
    else if (inc) cnt_d = cnt_q + 1'b1;
    ovf_d = ovf_q;
    if (wr_ovf && wdata[0]) ovf_d = 1'b0;
    if (wrap)               ovf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      cnt_q <= '0;
      en_q  <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      sel_q <= sel_d;
      cnt_q <= cnt_d;
      en_q  <= en_d;
      ovf_q <= ovf_d;
    end
  end

  // R7
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (g_en && en_q && evt_hit && !wr_cnt && (&cnt_q)) |=> (ovf_q && cnt_q == '0));
  // R7
  ovf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ovf && wdata[0] && !(g_en && en_q && evt_hit && !wr_cnt && (&cnt_q))) |=> !ovf_q);
  // R8
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> (cnt_q == $past(wdata)));
  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(g_en && en_q) && !wr_cnt) |=> $stable(cnt_q));
  // R6
  bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!code_ok && !wr_cnt) |=> $stable(cnt_q));
endmodule

// File: rtl/perf_mon_top.sv
module perf_mon_top import perfmon_pkg::*; #(
  parameter int NUM_EVT_CNT    = 4,
  parameter int CNT_W          = 32,
  parameter int ADDR_W         = 16,
  parameter int SLV_MAX_CODE   = 20,
  parameter int MST_MAX_CODE   = 17,
  parameter int FIRST_MST_PORT = 5,
  parameter int REV_ID         = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic [DATA_W-1:0]      rd_data,
  input  logic [EVT_W-1:0]       evt_pulse,
  output logic [NUM_EVT_CNT:0]   ovf_irq
);
  localparam int NUM_CNT = NUM_EVT_CNT + 1;
  localparam int PAGE_W  = ADDR_W - WIN_LSB;

  logic [1:0]        rst_sync;
  logic              rst_n_s;
  logic [PAGE_W-1:0] page;
  logic [OFF_W-1:0]  off;
  logic              wr_stb, rd_stb, g_en_q, g_en_d;
  logic [DATA_W-1:0] rd_next, rd_q, gctl_rd, id_rd;

  logic [NUM_CNT-1:0][SEL_W-1:0] sel_q;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q;
  logic [NUM_CNT-1:0]            en_q, ovf_q, hit, code_ok;

  // reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  always_comb begin
    page   = req_addr[ADDR_W-1:WIN_LSB];
    off    = req_addr[OFF_W-1:0];
    wr_stb = req_valid & req_write;
    rd_stb = req_valid & ~req_write;
    g_en_d = (wr_stb && page == '0 && off == OFF_GCTL) ? req_wdata[0] : g_en_q;
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_slot
    logic pg;
    assign pg = wr_stb && (page == PAGE_W'(i));
    if (i == 0) begin : g_cycle
      assign hit[i]     = 1'b1;
      assign code_ok[i] = 1'b1;
    end else begin : g_event
      pm_event_filter #(
        .SLV_MAX_CODE(SLV_MAX_CODE), .MST_MAX_CODE(MST_MAX_CODE),
        .FIRST_MST_PORT(FIRST_MST_PORT)
      ) u_filt (
        .sel(sel_q[i]), .evt(evt_pulse), .code_ok(code_ok[i]), .hit(hit[i])
      );
    end
    pm_counter_slot #(.CNT_W(CNT_W)) u_slot (
      .clk(clk), .rst_n(rst_n_s), .g_en(g_en_q), .evt_hit(hit[i]),
      .code_ok(code_ok[i]),
      .wr_sel(pg && off == OFF_SEL), .wr_cnt(pg && off == OFF_CNT),
      .wr_ctl(pg && off == OFF_CTL), .wr_ovf(pg && off == OFF_OVF),
      .wdata(req_wdata[CNT_W-1:0]),
      .sel_q(sel_q[i]), .cnt_q(cnt_q[i]), .en_q(en_q[i]), .ovf_q(ovf_q[i])
    );
  end

  always_comb begin
    gctl_rd = '0;
    gctl_rd[0] = g_en_q;
    gctl_rd[NCNT_LSB +: NCNT_W] = NCNT_W'(NUM_EVT_CNT);
    id_rd = '0;
    id_rd[REV_LSB +: 4] = 4'(REV_ID);
    rd_next = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (page == PAGE_W'(i)) begin
        case (off)
          OFF_SEL: rd_next = DATA_W'(sel_q[i]);
          OFF_CNT: rd_next = DATA_W'(cnt_q[i]);
          OFF_CTL: rd_next = DATA_W'(en_q[i]);
          OFF_OVF: rd_next = DATA_W'(ovf_q[i]);
          default: ;
        endcase
      end
    end
    if (page == '0 && off == OFF_GCTL) rd_next = gctl_rd;
    if (page == '0 && off == OFF_ID)   rd_next = id_rd;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      g_en_q <= 1'b0;
      rd_q   <= '0;
    end else begin
      g_en_q <= g_en_d;
      if (rd_stb) rd_q <= rd_next;
    end
  end

  assign rd_data = rd_q;
  assign ovf_irq = ovf_q;

  // R9
  gctl_field_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_stb && page == '0 && off == OFF_GCTL)
      |=> (rd_data[NCNT_LSB +: NCNT_W] == NCNT_W'(NUM_EVT_CNT)));
  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !rd_stb |=> $stable(rd_data));
endmodule

// File: tb/tb_perf_mon_top.sv
`timescale 1ns/1ps
module tb_perf_mon_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid, req_write;
  logic [15:0]  req_addr;
  logic [31:0]  req_wdata, rd_data;
  logic [255:0] evt_pulse;
  logic [4:0]   ovf_irq;

  int checks = 0;
  int errors = 0;
  logic rd_pend = 1'b0;
  bit   done = 1'b0;

  typedef struct { logic [31:0] val; string tag; } exp_t;
  exp_t sb_q[$];

  always #5 clk = ~clk;

  perf_mon_top dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
    .evt_pulse(evt_pulse), .ovf_irq(ovf_irq)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compare read data the cycle after each read request
  always @(posedge clk) rd_pend <= req_valid & ~req_write;
  always @(negedge clk) begin
    if (rd_pend) begin
      if (sb_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R11 unexpected read data actual=%h expected=none", rd_data);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(rd_data, e.val, e.tag);
      end
    end
  end

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [31:0] exp, input string tag);
    exp_t e;
    e.val = exp; e.tag = tag;
    sb_q.push_back(e);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] ra(input int idx, input logic [11:0] off);
    return 16'(idx * 16'h1000) | {4'h0, off};
  endfunction

  initial begin
    #500000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; evt_pulse = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    chk({27'h0, ovf_irq}, 32'h0, "R1 irq after reset");
    rd(16'h0100, 32'h0000_2000, "R1 global ctl after reset");
    rd(ra(1, 12'h004), 32'h0, "R1 count1 after reset");
    rd(ra(3, 12'h000), 32'h0, "R1 select3 after reset");
    rd(ra(2, 12'h00C), 32'h0, "R1 overflow2 after reset");
    rd(16'h0FE8, 32'h0000_0050, "R9 id revision");

    // R2 layout and readback
    wr(ra(1, 12'h000), 32'h94);   // port4 code 0x14: valid slave edge
    wr(ra(2, 12'h000), 32'h35);   // port1 code 0x15: invalid slave
    wr(ra(3, 12'h000), 32'hD2);   // port6 code 0x12: invalid master
    wr(ra(4, 12'h000), 32'hF1);   // port7 code 0x11: valid master edge
    wr(ra(0, 12'h004), 32'h10);
    for (int i = 1; i <= 4; i++) wr(ra(i, 12'h008), 32'h1);
    rd(ra(1, 12'h000), 32'h94, "R2 select1 readback");
    rd(ra(4, 12'h000), 32'hF1, "R2 select4 readback");
    rd(ra(0, 12'h004), 32'h10, "R2 count0 readback");
    rd(ra(2, 12'h008), 32'h1, "R2 ctl2 readback");
    rd(ra(0, 12'h008), 32'h0, "R2 ctl0 untouched");

    // R3 global enable off: nothing counts
    evt_pulse = '1;
    idle(3);
    evt_pulse = '0;
    rd(ra(1, 12'h004), 32'h0, "R3 count1 with global off");

    // R6 all pulses high for 5 cycles
    wr(16'h0100, 32'h1);
    evt_pulse = '1;
    idle(5);
    evt_pulse = '0;
    wr(16'h0100, 32'h0);
    rd(ra(1, 12'h004), 32'h5, "R6 slave code 0x14 counts");
    rd(ra(2, 12'h004), 32'h0, "R6 slave code 0x15 ignored");
    rd(ra(3, 12'h004), 32'h0, "R6 master code 0x12 ignored");
    rd(ra(4, 12'h004), 32'h5, "R6 master code 0x11 counts");
    rd(ra(0, 12'h004), 32'h10, "R3 counter0 local off holds");

    // R4 cycle counter ignores select, counts every enabled cycle
    wr(ra(0, 12'h000), 32'hFF);
    wr(ra(0, 12'h008), 32'h1);
    wr(16'h0100, 32'h1);
    idle(3);
    wr(16'h0100, 32'h0);
    rd(ra(0, 12'h004), 32'h14, "R4 cycle count");
    rd(ra(0, 12'h000), 32'hFF, "R2 select0 readback");
    wr(ra(0, 12'h008), 32'h0);

    // R5 selection: other bits high do not move counters
    wr(16'h0100, 32'h1);
    evt_pulse = '1;
    evt_pulse[148] = 1'b0;
    evt_pulse[241] = 1'b0;
    idle(3);
    evt_pulse = '0;
    evt_pulse[148] = 1'b1;
    idle(2);
    evt_pulse = '0;
    wr(16'h0100, 32'h0);
    rd(ra(1, 12'h004), 32'h7, "R5 count1 only own bit");
    rd(ra(4, 12'h004), 32'h5, "R5 count4 unselected bits");
    rd(16'h0100, 32'h0000_2000, "R9 global enable readback off");

    // R7 wrap and overflow
    wr(ra(1, 12'h004), 32'hFFFF_FFFE);
    wr(16'h0100, 32'h1);
    evt_pulse[148] = 1'b1;
    idle(3);
    evt_pulse = '0;
    wr(16'h0100, 32'h0);
    chk({27'h0, ovf_irq}, 32'h2, "R7 irq1 after wrap");
    rd(ra(1, 12'h004), 32'h1, "R7 count after wrap");
    rd(ra(1, 12'h00C), 32'h1, "R7 overflow flag set");
    wr(ra(1, 12'h00C), 32'h0);
    rd(ra(1, 12'h00C), 32'h1, "R7 write 0 keeps flag");
    wr(ra(1, 12'h00C), 32'h1);
    rd(ra(1, 12'h00C), 32'h0, "R7 write 1 clears flag");
    chk({27'h0, ovf_irq}, 32'h0, "R7 irq low after clear");

    // R8 write beats increment
    wr(16'h0100, 32'h1);
    evt_pulse[241] = 1'b1;
    wr(ra(4, 12'h004), 32'h100);
    evt_pulse = '0;
    wr(16'h0100, 32'h0);
    rd(ra(4, 12'h004), 32'h100, "R8 write priority");

    // R10 unmapped and read-only
    rd(16'h5004, 32'h0, "R10 window 5 reads zero");
    rd(16'h0010, 32'h0, "R10 unmapped offset reads zero");
    rd(16'h1100, 32'h0, "R10 global only in window 0");
    wr(16'h0FE8, 32'h0);
    rd(16'h0FE8, 32'h0000_0050, "R10 id write ignored");
    wr(16'h0100, 32'hFFFF_FFFF);
    rd(16'h0100, 32'h0000_2001, "R10 counter-count field read-only");
    wr(16'h0100, 32'h0);
    wr(16'h6004, 32'h1234);
    rd(ra(2, 12'h004), 32'h0, "R10 unmapped write no effect");

    // R11 read data holds
    rd(ra(4, 12'h000), 32'hF1, "R11 read latency");
    idle(3);
    chk(rd_data, 32'hF1, "R11 read data holds");

    idle(2);
    if (sb_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R11 missing read data actual=%0d expected=0", sb_q.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule